// File: doc/BRIEF.md
# APB Requester with Two-Completer Decode

This block converts simple local commands into APB transfers aimed at one of two completers. The local side supplies a command strobe, a read enable and a write enable that are never both high, a read address and a separate write address (9 bits each), and 8-bit write data. The block returns the 8-bit data of the most recent read and a flag that holds the error response of the most recent transfer.

On the bus side the block runs the usual three-phase sequence of idle, setup and access. It drives two select lines, the enable, the direction, the address and the write data, and it samples ready, error and read data from the completers. Address bit 7 selects the completer. A transfer may hold the access phase for any number of wait cycles. If another command is pending when a transfer completes, the block goes straight to the next setup phase and does not pass through idle, so a stream of reads and writes runs back-to-back.

Top module: `apb_dual_requester`

## Requirements
- R1: When `cmdValid` is high and one of `cmdRead`/`cmdWrite` is high, the block accepts the command from idle. The next cycle is a single setup cycle (one select high, `busEnable` low), and the cycle after that is the access phase.
- R2: A write command drives `busAddr` from `wrAddr`, `busWrite`=1 and `busWdata` from `wrData`. A read command drives `busAddr` from `rdAddr` and `busWrite`=0. If both enables are high, the write wins.
- R3: Address bit 7 picks the completer: 0 raises `selLow` and 1 raises `selHigh`. Address 0x005 raises `selLow` only and address 0x085 raises `selHigh` only. Exactly one select is high in setup and access, and neither is high in idle.
- R4: `busEnable` is high only in the access phase.
- R5: While `busReady` is low in the access phase, the block stays in that phase and `busAddr`, `busWrite`, `busWdata` and the selects do not change.
- R6: A transfer completes on the first access cycle that has `busReady` high. If a command is pending at that edge, the next cycle is setup, with no idle cycle between.
- R7: `rdDataOut` takes `busRdata` only at the completion of a read. It keeps its value at every other time, including across writes.
- R8: `errOut` takes `busErr` at each completion and holds it until the next completion. With a completer that flags an error for any address whose bit 8 is set, a write to 0x1FF gives `errOut`=1.
- R9: While `rstN` is low, every output is 0 and no command is accepted.
- R10: `busReady`, `busErr` and `busRdata` have no effect outside the access phase.
- R11: `cmdValid` high with neither enable high starts no transfer: both selects stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command present |
| cmdRead | input | 1 | Command is a read |
| cmdWrite | input | 1 | Command is a write |
| wrAddr | input | 9 | Address used by writes |
| wrData | input | 8 | Data for writes |
| rdAddr | input | 9 | Address used by reads |
| busReady | input | 1 | Completer ready |
| busErr | input | 1 | Completer error response |
| busRdata | input | 8 | Completer read data |
| selLow | output | 1 | Select for the completer with address bit 7 = 0 |
| selHigh | output | 1 | Select for the completer with address bit 7 = 1 |
| busEnable | output | 1 | Access-phase enable |
| busWrite | output | 1 | Transfer direction, 1 = write |
| busAddr | output | 9 | Transfer address |
| busWdata | output | 8 | Transfer write data |
| rdDataOut | output | 8 | Data of the last completed read |
| errOut | output | 1 | Error response of the last completed transfer |

## Verification
The hardest case to reach is a chained completion. It needs the next command present at exactly the edge where a waited access phase ends, and it needs stray ready, error and data values on the bus in the cycles around that edge. The bench keeps a queue of commands and puts the next one on the inputs in the same cycle the previous one is accepted, so the new command is already waiting during setup and access. A bench-side completer adds a configurable number of wait cycles and can drive noise values outside the access phase. A behavioural model tracks the phase and the registered values every cycle.

// File: rtl/apb_req_pkg.sv
package apb_req_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } phase_e;

  typedef struct packed {
    logic load;    // capture the local command this edge
    logic done;    // access phase completes this edge
    logic busy;    // setup or access phase
    logic access;  // access phase
  } ctl_strobe_t;
endpackage

// File: rtl/apb_req_ctrl.sv
module apb_req_ctrl
  import apb_req_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdRead,
  input  logic        cmdWrite,
  input  logic        busReady,
  output ctl_strobe_t strobe
);
  phase_e phase, phaseNext;
  logic   cmdGo;

  always_comb begin
    cmdGo         = cmdValid & (cmdRead | cmdWrite);
    strobe.access = (phase == PH_ACCESS);
    strobe.busy   = (phase != PH_IDLE);
    strobe.done   = strobe.access & busReady;
    strobe.load   = cmdGo & ((phase == PH_IDLE) | strobe.done);
  end

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_IDLE:   if (cmdGo) phaseNext = PH_SETUP;
      PH_SETUP:  phaseNext = PH_ACCESS;
      PH_ACCESS: if (busReady) phaseNext = cmdGo ? PH_SETUP : PH_IDLE;
      default:   phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assert_setup_one_cycle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SETUP) |=> (phase == PH_ACCESS));

  assert_hold_access_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ACCESS && !busReady) |=> (phase == PH_ACCESS));

  assert_chain_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ACCESS && busReady && cmdValid && (cmdRead || cmdWrite)) |=> (phase == PH_SETUP));

  assert_no_spurious_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && !(cmdRead || cmdWrite)) |=> (phase == PH_IDLE));
endmodule

// File: rtl/apb_req_dpath.sv
module apb_req_dpath
  import apb_req_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 8,
  parameter int DEC_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strobe,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busErr,
  input  logic [DATA_W-1:0] busRdata,
  output logic              selLow,
  output logic              selHigh,
  output logic              busEnable,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rdDataOut,
  output logic              errOut
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic              writeQ, errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      writeQ <= 1'b0;
    end else if (strobe.load) begin
      writeQ <= cmdWrite;
      addrQ  <= cmdWrite ? wrAddr : rdAddr;
      if (cmdWrite) wdataQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
      errQ   <= 1'b0;
    end else if (strobe.done) begin
      errQ <= busErr;
      if (!writeQ) rdataQ <= busRdata;
    end
  end

  always_comb begin
    selLow    = strobe.busy & ~addrQ[DEC_BIT];
    selHigh   = strobe.busy &  addrQ[DEC_BIT];
    busEnable = strobe.access;
    busWrite  = writeQ;
    busAddr   = addrQ;
    busWdata  = wdataQ;
    rdDataOut = rdataQ;
    errOut    = errQ;
  end

  assert_select_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    busEnable |-> $onehot({selLow, selHigh}));

  assert_stable_access_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.access && !strobe.done) |=> ($stable(busAddr) && $stable(busWrite) && $stable(busWdata)));

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.done && !busWrite) |=> $stable(rdDataOut));

  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.done |=> $stable(errOut));
endmodule

// File: rtl/apb_dual_requester.sv
module apb_dual_requester
  import apb_req_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int DATA_W  = 8,
  parameter int DEC_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdRead,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              busReady,
  input  logic              busErr,
  input  logic [DATA_W-1:0] busRdata,
  output logic              selLow,
  output logic              selHigh,
  output logic              busEnable,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rdDataOut,
  output logic              errOut
);
  ctl_strobe_t strobe;

  apb_req_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRead(cmdRead),
    .cmdWrite(cmdWrite), .busReady(busReady), .strobe(strobe)
  );

  apb_req_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEC_BIT(DEC_BIT)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdWrite(cmdWrite),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .busErr(busErr),
    .busRdata(busRdata), .selLow(selLow), .selHigh(selHigh),
    .busEnable(busEnable), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .rdDataOut(rdDataOut), .errOut(errOut)
  );

  assert_enable_only_access_R4: assert property (@(posedge clk) disable iff (!rstN)
    (selLow || selHigh) && !busEnable |=> busEnable);
endmodule

// File: tb/apb_dual_requester_tb.sv
module apb_dual_requester_tb;
  localparam int KGAP = 0, KNOOP = 1, KCMD = 2;
  typedef struct packed {
    logic [1:0] kind;
    logic       wr;
    logic       rd;
    logic [8:0] addr;
    logic [7:0] data;
  } entry_t;

  logic clk = 0, rstN = 0;
  logic cmdValid = 0, cmdRead = 0, cmdWrite = 0;
  logic [8:0] wrAddr = 0, rdAddr = 0;
  logic [7:0] wrData = 0;
  logic busReady = 0, busErr = 0;
  logic [7:0] busRdata = 0;
  logic selLow, selHigh, busEnable, busWrite, errOut;
  logic [8:0] busAddr;
  logic [7:0] busWdata, rdDataOut;

  apb_dual_requester u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRead(cmdRead),
    .cmdWrite(cmdWrite), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .busReady(busReady), .busErr(busErr), .busRdata(busRdata),
    .selLow(selLow), .selHigh(selHigh), .busEnable(busEnable),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .rdDataOut(rdDataOut), .errOut(errOut)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;
  entry_t q[$];
  int curKind = KGAP;
  int waitCfg = 0, waitCnt = 0;
  bit readyNoise = 0;
  logic [7:0] mem [256];

  // behavioural reference state
  int mState = 0;
  logic [8:0] mAddr;
  logic mWr, mErr, mLoaded;
  logic [7:0] mData, mRd;

  // observation counters
  logic [1:0] seen005 = 0, seen085 = 0;
  int enCycles = 0, selCycles = 0, burstIdle = 0;
  bit burstOn = 0;

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // reference model, updated at each active edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mAddr = 0; mWr = 0; mData = 0; mRd = 0; mErr = 0; mLoaded = 0;
    end else begin
      bit go, ld;
      go = cmdValid && (cmdRead || cmdWrite);
      ld = 0;
      case (mState)
        0: if (go) ld = 1;
        1: mState = 2;
        default: if (busReady) begin
          mErr = busErr;
          if (!mWr) mRd = busRdata;
          else if (!busErr) mem[mAddr[7:0]] = mData;
          if (go) ld = 1; else mState = 0;
        end
      endcase
      if (ld) begin
        mState = 1;
        mWr = cmdWrite;
        mAddr = cmdWrite ? wrAddr : rdAddr;
        if (cmdWrite) mData = wrData;
      end
      mLoaded = ld;
    end
  end

  // compare, completer, command feed
  always @(negedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      chk(0, "watchdog", cycles, 20000);
      finishRun();
    end
    chk(selLow == (mState != 0 && !mAddr[7]), "R3 selLow", selLow, (mState != 0 && !mAddr[7]));
    chk(selHigh == (mState != 0 && mAddr[7]), "R3 selHigh", selHigh, (mState != 0 && mAddr[7]));
    chk(busEnable == (mState == 2), "R4 busEnable", busEnable, (mState == 2));
    chk(busAddr == mAddr && busWrite == mWr && busWdata == mData, "R2/R5 addr-dir-data",
        {busWrite, busAddr, busWdata}, {mWr, mAddr, mData});
    chk(rdDataOut == mRd, "R7 rdDataOut", rdDataOut, mRd);
    chk(errOut == mErr, "R8 errOut", errOut, mErr);
    if (busEnable && busAddr == 9'h005) seen005 = {selLow, selHigh};
    if (busEnable && busAddr == 9'h085) seen085 = {selLow, selHigh};
    if (busEnable) enCycles++;
    if (selLow || selHigh) selCycles++;
    if (selLow || selHigh) burstOn = 1;
    else if (burstOn && cmdValid) burstIdle++;
    // completer
    if (busEnable) begin
      if (waitCnt == waitCfg) begin
        busReady = 1; busErr = busAddr[8]; busRdata = mem[busAddr[7:0]];
      end else begin
        busReady = 0; busErr = 1; busRdata = 8'hEE; waitCnt++;
      end
    end else begin
      waitCnt = 0;
      busReady = readyNoise; busErr = readyNoise; busRdata = readyNoise ? 8'hEE : 8'h00;
    end
    // command feed
    if (curKind != KCMD || mLoaded) begin
      if (q.size() > 0) begin
        entry_t e;
        e = q.pop_front();
        curKind = e.kind;
        cmdValid = (e.kind != KGAP);
        cmdWrite = e.wr; cmdRead = e.rd;
        wrAddr = e.wr ? e.addr : ~e.addr;
        rdAddr = e.rd ? e.addr : ~e.addr;
        wrData = e.data;
      end else begin
        curKind = KGAP; cmdValid = 0; cmdRead = 0; cmdWrite = 0;
      end
    end
  end

  task automatic push(input int kind, input bit wr, input bit rd, input logic [8:0] a, input logic [7:0] d);
    entry_t e;
    e.kind = kind[1:0]; e.wr = wr; e.rd = rd; e.addr = a; e.data = d;
    q.push_back(e);
  endtask

  task automatic drain();
    @(negedge clk);
    while (q.size() != 0 || curKind != KGAP || mState != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = i[7:0] ^ 8'h3C;
    // R9: a command waits during reset and must not start
    push(KCMD, 1, 0, 9'h005, 8'hA5);
    repeat (5) @(negedge clk);
    chk({selLow, selHigh, busEnable, busWrite, busAddr, busWdata, rdDataOut, errOut} == '0,
        "R9 outputs in reset", {selLow, selHigh, busEnable}, 0);
    chk(selCycles == 0, "R9 no transfer in reset", selCycles, 0);
    rstN = 1;
    push(KCMD, 1, 0, 9'h085, 8'h5A);
    drain();
    chk(seen005 == 2'b10, "R3 0x005 selects low only", seen005, 2'b10);
    chk(seen085 == 2'b01, "R3 0x085 selects high only", seen085, 2'b01);
    // R7 reads back
    push(KCMD, 0, 1, 9'h005, 8'h00);
    drain();
    chk(rdDataOut == 8'hA5, "R7 read 0x005", rdDataOut, 8'hA5);
    push(KCMD, 0, 1, 9'h085, 8'h00);
    push(KGAP, 0, 0, 0, 0);
    push(KCMD, 1, 0, 9'h011, 8'h77);
    drain();
    chk(rdDataOut == 8'h5A, "R7 held across write", rdDataOut, 8'h5A);
    // R5 wait states
    waitCfg = 3;
    enCycles = 0;
    push(KCMD, 1, 0, 9'h010, 8'hBB);
    drain();
    chk(enCycles == 4, "R5 access held for waits", enCycles, 4);
    push(KCMD, 0, 1, 9'h010, 8'h00);
    drain();
    chk(rdDataOut == 8'hBB, "R5 read after waits", rdDataOut, 8'hBB);
    waitCfg = 0;
    // R8 error capture
    push(KCMD, 1, 0, 9'h1FF, 8'hFF);
    drain();
    chk(errOut == 1'b1, "R8 error on 0x1FF", errOut, 1);
    push(KCMD, 1, 0, 9'h020, 8'h12);
    drain();
    chk(errOut == 1'b0, "R8 error cleared", errOut, 0);
    // R6 back-to-back burst with waits
    waitCfg = 1;
    burstOn = 0; burstIdle = 0;
    push(KCMD, 1, 0, 9'h001, 8'h11); push(KCMD, 0, 1, 9'h001, 8'h00);
    push(KCMD, 1, 0, 9'h002, 8'h22); push(KCMD, 0, 1, 9'h002, 8'h00);
    push(KCMD, 1, 0, 9'h183, 8'h33); push(KCMD, 0, 1, 9'h003, 8'h00);
    drain();
    burstOn = 0;
    chk(burstIdle == 0, "R6 no idle inside burst", burstIdle, 0);
    chk(rdDataOut == 8'h3F, "R6 last burst read", rdDataOut, 8'h3F);
    // R11 command with neither enable
    selCycles = 0;
    push(KNOOP, 0, 0, 9'h005, 8'h00); push(KNOOP, 0, 0, 9'h085, 8'h00);
    drain();
    chk(selCycles == 0, "R11 no transfer without enable", selCycles, 0);
    // R10 bus noise outside access
    readyNoise = 1;
    push(KCMD, 0, 1, 9'h002, 8'h00);
    drain();
    chk(rdDataOut == 8'h22 && errOut == 1'b0, "R10 noise ignored", {errOut, rdDataOut}, 9'h022);
    // R1 R2 mixed random traffic
    waitCfg = 2;
    for (int i = 0; i < 40; i++) begin
      logic w;
      w = $urandom_range(0, 1);
      push(($urandom_range(0, 5) == 0) ? KGAP : KCMD, w, !w, $urandom_range(0, 511), $urandom_range(0, 255));
    end
    drain();
    readyNoise = 0;
    finishRun();
  end
endmodule